// File: doc/BRIEF.md
# Selectable-Source Wake-Up Time Base

This block is a free-running 15-bit up-counter used two ways. Software can read it as a plain time base. It also acts as a periodic interrupt source that can bring the device out of a low-power idle state. The counter advances on strobes from one of three clock-enable sources: a slow clock, the system clock divided by 128, or the fast internal RC oscillator divided by 512. A 2-bit field picks one of four interrupt periods. Each period is a tap on the upper part of the count chain.

The oscillators and the prescalers are out of scope, and so is the sleep controller. Each source therefore arrives as a one-cycle enable strobe in the single clock domain. A 2-bit power-mode level sets whether counting is allowed. A small three-state controller follows that level:

- State `ST_RUN`: normal operation, counting.
- State `ST_IDLE`: low-power idle, still counting.
- State `ST_STOP`: frozen.

The transitions between these states are:

- enter-idle: `ST_RUN` to `ST_IDLE`.
- leave-idle: `ST_IDLE` to `ST_RUN`.
- enter-stop: `ST_RUN` or `ST_IDLE` to `ST_STOP`.
- resume: `ST_STOP` to `ST_RUN` or `ST_IDLE`.

When the selected tap falls, a sticky interrupt flag sets. Software clears the flag with a write-one-to-clear strobe. The flag, gated by an enable bit, is driven out as a wake request in every mode.

Top module: `wkt_timebase`

## Requirements
- R1: After reset, `count_o` is 0, `irq_flag_o` is 0 and `wake_req_o` is 0.
- R2: `src_sel` 00 selects `tick_slow`, 01 selects `tick_sys128` and 10 selects `tick_firc512`. Code 11 selects no source. When counting is allowed, `count_o` rises by exactly one at each clock edge where the selected strobe is high. Strobes from sources that are not selected have no effect.
- R3: Interval code k (`ivl_sel` 0 to 3) uses tap bit 11+k. Starting from zero, `irq_flag_o` sets on the 2^(12+k)-th counted strobe, which is the edge where that bit falls. It does not set before that strobe.
- R4: `irq_flag_o` stays set until a clock edge where `flag_clr` is high. At that edge it clears. If a new interval event occurs at the same edge as `flag_clr`, the flag remains set.
- R5: `wake_req_o` is high exactly when `irq_flag_o` and `irq_en` are both high, in every power mode.
- R6: `pwr_mode` 00 means run, 01 means idle, and 10 or 11 means stop. The controller takes the new mode at the next edge. From the edge after that, counting follows the new state. The counter counts in run and idle, and holds its value in stop.
- R7: When `cnt_clr` is high at an edge, `count_o` becomes 0 at that edge, even if a strobe is present. `irq_flag_o` is not affected.
- R8: When `src_sel` or `ivl_sel` differs from its value at the previous edge, `count_o` becomes 0 at that edge and any strobe is ignored. The first period after a change is therefore a full period.
- R9: The counter wraps from 0x7FFF to 0 and then keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_slow | input | 1 | Slow-clock enable strobe |
| tick_sys128 | input | 1 | System clock /128 enable strobe |
| tick_firc512 | input | 1 | Fast internal RC /512 enable strobe |
| src_sel | input | 2 | Count source select (11 = none) |
| ivl_sel | input | 2 | Interrupt interval select, tap bit 11+code |
| pwr_mode | input | 2 | Power mode: 00 run, 01 idle, 1x stop |
| cnt_clr | input | 1 | Synchronous counter clear |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_en | input | 1 | Interrupt and wake enable |
| count_o | output | 15 | Current count |
| irq_flag_o | output | 1 | Sticky interval flag |
| wake_req_o | output | 1 | Wake request (flag AND enable) |

## Verification
Strobes, clears, configuration changes and flag clears all take effect at the first rising edge after they are driven. A mode change needs one more edge, because it first passes through the state register. The bench drives every input just after a falling edge. It reads results at the next falling edge, or at the one after that when the mode has changed. It always idles one cycle with no strobe after changing the mode or the configuration, so no counted strobe can fall into the latency window. Expected counts and flag edges are worked out in the bench from powers of two over the interval codes, with a separate case for each source and each strobe line.

// File: rtl/wkt_pkg.sv
package wkt_pkg;

    // Power-mode level codes seen on the pwr_mode input
    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_STOP  = 2'b10,
        PM_STOP2 = 2'b11
    } pmode_e;

    // Mode controller states
    typedef enum logic [1:0] {
        ST_RUN  = 2'b00,
        ST_IDLE = 2'b01,
        ST_STOP = 2'b10
    } wkt_state_e;

endpackage

// File: rtl/wkt_src_mux.sv
module wkt_src_mux #(
    parameter int NUM_SRC = 3,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_SRC-1:0] ticks_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic               tick_o
);

    // One decoded enable per source; codes at or above NUM_SRC select nothing
    logic [NUM_SRC-1:0] hit;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = (sel_i == SEL_W'(i)) & ticks_i[i];
    end

    assign tick_o = |hit;

endmodule

// File: rtl/wkt_mode_fsm.sv
module wkt_mode_fsm
    import wkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pwr_mode,
    output wkt_state_e state_o,
    output logic       cnt_en_o
);

    wkt_state_e state_q;
    wkt_state_e state_d;
    logic       want_stop;
    logic       want_idle;

    assign want_stop = pwr_mode[1];
    assign want_idle = (pwr_mode == PM_IDLE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: enter-idle, leave-idle, enter-stop, resume
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (want_stop) begin
                    state_d = ST_STOP;
                end else if (want_idle) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (want_stop) begin
                    state_d = ST_STOP;
                end else if (!want_idle) begin
                    state_d = ST_RUN;
                end
            end
            ST_STOP: begin
                if (!want_stop) begin
                    state_d = want_idle ? ST_IDLE : ST_RUN;
                end
            end
            default: state_d = ST_RUN;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        cnt_en_o = 1'b0;
        unique case (state_q)
            ST_RUN:  cnt_en_o = 1'b1;
            ST_IDLE: cnt_en_o = 1'b1;
            ST_STOP: cnt_en_o = 1'b0;
            default: cnt_en_o = 1'b0;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int CNT_W = 15,
    parameter int IVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cnt_en_i,
    input  logic             clr_i,
    input  logic [IVL_W-1:0] ivl_sel_i,
    output logic [CNT_W-1:0] count_o,
    output logic             event_o
);

    localparam int NUM_IVL = 2 ** IVL_W;
    localparam int TAP_LO  = CNT_W - NUM_IVL;

    logic [CNT_W-1:0]   cnt_q;
    logic [NUM_IVL-1:0] low_full;
    logic               inc;

    assign inc = tick_i & cnt_en_i & ~clr_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The tap falls on the increment that carries out of all bits up to it
    for (genvar k = 0; k < NUM_IVL; k++) begin : g_tap
        assign low_full[k] = &cnt_q[TAP_LO+k:0];
    end

    assign event_o = inc & low_full[ivl_sel_i];
    assign count_o = cnt_q;

endmodule

// File: rtl/wkt_flag.sv
module wkt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/wkt_timebase.sv
module wkt_timebase
    import wkt_pkg::*;
#(
    parameter int CNT_W   = 15,
    parameter int IVL_W   = 2,
    parameter int SRC_W   = 2,
    parameter int NUM_SRC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_slow,
    input  logic             tick_sys128,
    input  logic             tick_firc512,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [IVL_W-1:0] ivl_sel,
    input  logic [1:0]       pwr_mode,
    input  logic             cnt_clr,
    input  logic             flag_clr,
    input  logic             irq_en,
    output logic [CNT_W-1:0] count_o,
    output logic             irq_flag_o,
    output logic             wake_req_o
);

    logic [NUM_SRC-1:0] ticks;
    logic               tick_sel;
    logic               cnt_en;
    logic               cfg_chg;
    logic               tap_event;
    logic               flag;
    logic [SRC_W-1:0]   src_q;
    logic [IVL_W-1:0]   ivl_q;
    wkt_state_e         fsm_state;

    assign ticks = {tick_firc512, tick_sys128, tick_slow};

    // Previous configuration, used to detect a change of source or interval
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= '0;
            ivl_q <= '0;
        end else begin
            src_q <= src_sel;
            ivl_q <= ivl_sel;
        end
    end

    assign cfg_chg = (src_sel != src_q) | (ivl_sel != ivl_q);

    wkt_src_mux #(
        .NUM_SRC(NUM_SRC),
        .SEL_W  (SRC_W)
    ) u_mux (
        .ticks_i(ticks),
        .sel_i  (src_sel),
        .tick_o (tick_sel)
    );

    wkt_mode_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwr_mode(pwr_mode),
        .state_o (fsm_state),
        .cnt_en_o(cnt_en)
    );

    wkt_counter #(
        .CNT_W(CNT_W),
        .IVL_W(IVL_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_sel),
        .cnt_en_i (cnt_en),
        .clr_i    (cnt_clr | cfg_chg),
        .ivl_sel_i(ivl_sel),
        .count_o  (count_o),
        .event_o  (tap_event)
    );

    wkt_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (tap_event),
        .clr_i (flag_clr),
        .flag_o(flag)
    );

    assign irq_flag_o = flag;
    assign wake_req_o = flag & irq_en;

endmodule

// File: rtl/wkt_checker.sv
module wkt_checker
    import wkt_pkg::*;
#(
    parameter int CNT_W = 15,
    parameter int IVL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_clr,
    input logic             flag_clr,
    input logic             irq_en,
    input logic             cfg_chg,
    input wkt_state_e       state,
    input logic [CNT_W-1:0] count_o,
    input logic             irq_flag_o,
    input logic             wake_req_o
);

    localparam int TAP_LO = CNT_W - (2 ** IVL_W);

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag_o && !flag_clr) |=> irq_flag_o);

    assert_wake_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req_o |-> (irq_flag_o && irq_en));

    assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr |=> (count_o == '0));

    assert_cfg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> (count_o == '0));

    assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP && !cnt_clr && !cfg_chg) |=> $stable(count_o));

    assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_clr && !cfg_chg) |=>
            (count_o == $past(count_o) || count_o == CNT_W'($past(count_o) + 1'b1)));

    assert_flag_on_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag_o) |-> (count_o[TAP_LO:0] == '0));

endmodule

bind wkt_timebase wkt_checker #(
    .CNT_W(CNT_W),
    .IVL_W(IVL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_clr   (cnt_clr),
    .flag_clr  (flag_clr),
    .irq_en    (irq_en),
    .cfg_chg   (cfg_chg),
    .state     (fsm_state),
    .count_o   (count_o),
    .irq_flag_o(irq_flag_o),
    .wake_req_o(wake_req_o)
);

// File: tb/test_wkt_timebase.sv
module test_wkt_timebase;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_slow = 1'b0;
    logic        tick_sys128 = 1'b0;
    logic        tick_firc512 = 1'b0;
    logic [1:0]  src_sel = 2'b00;
    logic [1:0]  ivl_sel = 2'b00;
    logic [1:0]  pwr_mode = 2'b00;
    logic        cnt_clr = 1'b0;
    logic        flag_clr = 1'b0;
    logic        irq_en = 1'b0;
    logic [14:0] count_o;
    logic        irq_flag_o;
    logic        wake_req_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wkt_timebase i_wkt_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_slow   (tick_slow),
        .tick_sys128 (tick_sys128),
        .tick_firc512(tick_firc512),
        .src_sel     (src_sel),
        .ivl_sel     (ivl_sel),
        .pwr_mode    (pwr_mode),
        .cnt_clr     (cnt_clr),
        .flag_clr    (flag_clr),
        .irq_en      (irq_en),
        .count_o     (count_o),
        .irq_flag_o  (irq_flag_o),
        .wake_req_o  (wake_req_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic set_tick(input int which, input logic v);
        tick_slow    = (which == 0) ? v : 1'b0;
        tick_sys128  = (which == 1) ? v : 1'b0;
        tick_firc512 = (which == 2) ? v : 1'b0;
    endtask

    task automatic pulse(input int which, input int n);
        set_tick(which, 1'b1);
        repeat (n) cyc();
        set_tick(which, 1'b0);
    endtask

    task automatic zero_and_clear();
        cnt_clr = 1'b1;
        flag_clr = 1'b1;
        cyc();
        cnt_clr = 1'b0;
        flag_clr = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 190000 && !done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int base;
        repeat (3) cyc();
        // R1 reset state
        chk("R1 count", int'(count_o), 0);
        chk("R1 flag", int'(irq_flag_o), 0);
        chk("R1 wake", int'(wake_req_o), 0);
        rst_n = 1'b1;
        cyc();

        // R2 sweep: every source code against every strobe line
        for (int s = 0; s < 4; s++) begin
            src_sel = 2'(s);
            cyc();
            for (int w = 0; w < 3; w++) begin
                zero_and_clear();
                pulse(w, 3);
                chk($sformatf("R2 src%0d line%0d", s, w), int'(count_o), (s == w) ? 3 : 0);
            end
        end

        // R3 and R9: all four intervals, flag edge at 2^(12+k)
        src_sel = 2'b00;
        irq_en = 1'b0;
        for (int k = 0; k < 4; k++) begin
            int per;
            per = 1 << (12 + k);
            ivl_sel = 2'(k);
            cyc();
            zero_and_clear();
            pulse(0, per - 1);
            chk($sformatf("R3 ivl%0d count before", k), int'(count_o), per - 1);
            chk($sformatf("R3 ivl%0d no early flag", k), int'(irq_flag_o), 0);
            pulse(0, 1);
            chk($sformatf("R3 ivl%0d flag set", k), int'(irq_flag_o), 1);
            chk($sformatf("R9 ivl%0d count wrap", k), int'(count_o), per % 32768);
            chk($sformatf("R5 ivl%0d wake off", k), int'(wake_req_o), 0);
        end
        // R9 keeps counting after wrap
        pulse(0, 5);
        chk("R9 count after wrap", int'(count_o), 5);

        // R4 flag holds, then clears; set beats clear
        pulse(0, 20);
        chk("R4 flag sticky", int'(irq_flag_o), 1);
        flag_clr = 1'b1;
        cyc();
        flag_clr = 1'b0;
        chk("R4 flag cleared", int'(irq_flag_o), 0);
        ivl_sel = 2'b00;
        cyc();
        zero_and_clear();
        pulse(0, 4095);
        flag_clr = 1'b1;
        pulse(0, 1);
        flag_clr = 1'b0;
        chk("R4 set wins over clear", int'(irq_flag_o), 1);

        // R5 wake follows flag and enable
        irq_en = 1'b1;
        cyc();
        chk("R5 wake on", int'(wake_req_o), 1);

        // R7 clear counter with strobe, flag kept
        pulse(0, 9);
        cnt_clr = 1'b1;
        pulse(0, 1);
        cnt_clr = 1'b0;
        chk("R7 count zero", int'(count_o), 0);
        chk("R7 flag kept", int'(irq_flag_o), 1);

        // R8 config change clears, strobe ignored
        pulse(0, 30);
        ivl_sel = 2'b01;
        pulse(0, 1);
        chk("R8 ivl change clears", int'(count_o), 0);
        pulse(0, 12);
        src_sel = 2'b01;
        pulse(1, 1);
        chk("R8 src change clears", int'(count_o), 0);

        // R6 stop holds, idle counts, wake in idle
        pulse(1, 6);
        base = int'(count_o);
        chk("R6 run counts", base, 6);
        pwr_mode = 2'b10;
        cyc();
        pulse(1, 10);
        chk("R6 stop holds", int'(count_o), base);
        pwr_mode = 2'b11;
        cyc();
        pulse(1, 4);
        chk("R6 stop code 11 holds", int'(count_o), base);
        pwr_mode = 2'b01;
        cyc();
        pulse(1, 7);
        chk("R6 idle counts", int'(count_o), base + 7);
        src_sel = 2'b00;
        ivl_sel = 2'b00;
        cyc();
        zero_and_clear();
        pulse(0, 4096);
        chk("R6 idle flag", int'(irq_flag_o), 1);
        chk("R5 idle wake", int'(wake_req_o), 1);
        irq_en = 1'b0;
        cyc();
        chk("R5 wake masked", int'(wake_req_o), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule